// File: doc/BRIEF.md
# Ordered-Commit Clock Divisor Register Bank

This block holds the loop parameters for the memory-clock synthesizer behind a pair of I/O ports. One port holds an index that picks a register. The other port reads or writes the register that index selects. Three adjacent indexes, starting at CCh, form the parameter group: the M divisor, the N divisor and a third loop parameter. A write to the data port lands in a staging copy that software can read back. The synthesizer is driven from a separate shadow copy.

The shadow copy changes only when the whole group has been written in ascending order. An order tracker follows the writes to the group. When the write to the last register completes the sequence, all three shadows load in the same clock and a one-cycle strobe is raised. The synthesizer uses that strobe to relock. A write out of order inside the group sends the tracker back to the start. Writes outside the group leave the tracker alone. The synthesizer therefore never runs from a mix of old and new values.

Top module: `pll_param_regs`

## Requirements
- R1: A write to I/O address 3D6h stores the low 8 bits of the write data as the current index. A read of 3D6h returns that index combinationally.
- R2: A write to 3D7h while the index is CCh, CDh or CEh loads the staging register for M, N or the third parameter respectively. A read of 3D7h with such an index returns that staging value.
- R3: A read of 3D7h with an index outside CCh..CEh returns 00h. A read of any address other than 3D6h and 3D7h returns 00h.
- R4: While reset is asserted, the shadow outputs take M=1Ch, N=4Ah and P=01h. The staging registers hold the same values, the index is 00h, the tracker is at its start and the commit strobe is low.
- R5: The shadow outputs change only on a commit. A commit is a data write at index CEh made while the last two group writes were CCh and then CDh. Writes to indexes outside the group may fall between them.
- R6: A data write at CDh that does not follow a CCh write clears the tracker, and so does a write at CEh that does not follow a CDh write. A write at CCh always starts a new sequence, even in the middle of one.
- R7: Data writes at indexes outside CCh..CEh, and writes to addresses other than 3D6h and 3D7h, change neither the tracker nor any register.
- R8: The commit strobe is high for exactly the one cycle that follows the committing write's clock edge. In that same cycle the shadows first show the new values.
- R9: On a commit, the third shadow takes the value carried by the committing write itself. The M and N shadows take their staging values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioAddr | input | 16 | I/O address of the current access |
| ioWrEn | input | 1 | Write strobe for the current access |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Read data, combinational from address and state |
| mDivOut | output | 8 | Shadow M divisor driving the synthesizer |
| nDivOut | output | 8 | Shadow N divisor driving the synthesizer |
| pParamOut | output | 8 | Shadow third loop parameter driving the synthesizer |
| commitPulse | output | 1 | One-cycle strobe raised when the shadows load |

## Verification
The bench builds the block with its default parameters: port addresses 3D6h/3D7h, group base CCh and reset divisors 1Ch/4Ah/01h. With these values every order case can be reached through plain port writes:
- a complete sequence;
- a restart on a repeated CCh;
- a CDh or CEh write out of order;
- a non-group index placed inside a sequence;
- a reset arriving partway through a sequence.

The staging values and the unimplemented indexes are read back at the data port to show which writes were stored and which had no effect.

// File: rtl/pll_param_pkg.sv
package pll_param_pkg;

  localparam int GROUP_N = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_GOT0 = 2'd1,
    SEQ_GOT1 = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic               idxLoad;
    logic [GROUP_N-1:0] stageLoad;
    logic               commit;
  } strobe_t;

endpackage

// File: rtl/pll_param_ctrl.sv
module pll_param_ctrl
  import pll_param_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03D6,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03D7,
  parameter logic [DATA_W-1:0] BASE_IDX   = 8'hCC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic [DATA_W-1:0] curIndex,
  output strobe_t           strobes
);

  localparam int OFF_W = $clog2(GROUP_N);

  seq_state_t seqState, seqNext;
  logic [DATA_W-1:0] idxDiff;
  logic              inGroup;
  logic [OFF_W-1:0]  grpOff;
  logic              dataWr;

  assign idxDiff = curIndex - BASE_IDX;
  assign inGroup = idxDiff < DATA_W'(GROUP_N);
  assign grpOff  = idxDiff[OFF_W-1:0];
  assign dataWr  = ioWrEn && (ioAddr == DATA_PORT);

  always_comb begin
    strobes         = '0;
    seqNext         = seqState;
    strobes.idxLoad = ioWrEn && (ioAddr == INDEX_PORT);
    if (dataWr && inGroup) begin
      strobes.stageLoad[grpOff] = 1'b1;
      case (grpOff)
        OFF_W'(0): seqNext = SEQ_GOT0;
        OFF_W'(1): seqNext = (seqState == SEQ_GOT0) ? SEQ_GOT1 : SEQ_IDLE;
        default: begin
          strobes.commit = (seqState == SEQ_GOT1);
          seqNext        = SEQ_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqState <= SEQ_IDLE;
    else       seqState <= seqNext;
  end

endmodule

// File: rtl/pll_param_dpath.sv
module pll_param_dpath
  import pll_param_pkg::*;
#(
  parameter int                        ADDR_W     = 16,
  parameter int                        DATA_W     = 8,
  parameter logic [ADDR_W-1:0]         INDEX_PORT = 16'h03D6,
  parameter logic [ADDR_W-1:0]         DATA_PORT  = 16'h03D7,
  parameter logic [DATA_W-1:0]         BASE_IDX   = 8'hCC,
  parameter logic [GROUP_N*DATA_W-1:0] DEF_VALS   = 24'h01_4A_1C
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobes,
  input  logic [ADDR_W-1:0]           ioAddr,
  input  logic [DATA_W-1:0]           ioWrData,
  output logic [DATA_W-1:0]           curIndex,
  output logic [DATA_W-1:0]           ioRdData,
  output logic [GROUP_N*DATA_W-1:0]   shadowFlat,
  output logic                        commitPulse
);

  logic [DATA_W-1:0] stageReg [GROUP_N];
  logic [DATA_W-1:0] idxDiff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIndex    <= '0;
      commitPulse <= 1'b0;
    end else begin
      if (strobes.idxLoad) curIndex <= ioWrData;
      commitPulse <= strobes.commit;
    end
  end

  for (genvar k = 0; k < GROUP_N; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageReg[k]                     <= DEF_VALS[k*DATA_W +: DATA_W];
        shadowFlat[k*DATA_W +: DATA_W]  <= DEF_VALS[k*DATA_W +: DATA_W];
      end else begin
        if (strobes.stageLoad[k]) stageReg[k] <= ioWrData;
        if (strobes.commit)
          shadowFlat[k*DATA_W +: DATA_W] <= strobes.stageLoad[k] ? ioWrData : stageReg[k];
      end
    end
  end

  assign idxDiff = curIndex - BASE_IDX;

  always_comb begin
    ioRdData = '0;
    if (ioAddr == INDEX_PORT)
      ioRdData = curIndex;
    else if (ioAddr == DATA_PORT) begin
      for (int k = 0; k < GROUP_N; k++)
        if (idxDiff == DATA_W'(k)) ioRdData = stageReg[k];
    end
  end

endmodule

// File: rtl/pll_param_regs.sv
module pll_param_regs
  import pll_param_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03D6,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03D7,
  parameter logic [DATA_W-1:0] BASE_IDX   = 8'hCC,
  parameter logic [DATA_W-1:0] DEF_M      = 8'h1C,
  parameter logic [DATA_W-1:0] DEF_N      = 8'h4A,
  parameter logic [DATA_W-1:0] DEF_P      = 8'h01
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic [DATA_W-1:0] mDivOut,
  output logic [DATA_W-1:0] nDivOut,
  output logic [DATA_W-1:0] pParamOut,
  output logic              commitPulse
);

  strobe_t                   strobes;
  logic [DATA_W-1:0]         curIndex;
  logic [GROUP_N*DATA_W-1:0] shadowFlat;

  pll_param_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_PORT(INDEX_PORT),
    .DATA_PORT(DATA_PORT), .BASE_IDX(BASE_IDX)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .curIndex(curIndex), .strobes(strobes)
  );

  pll_param_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_PORT(INDEX_PORT),
    .DATA_PORT(DATA_PORT), .BASE_IDX(BASE_IDX),
    .DEF_VALS({DEF_P, DEF_N, DEF_M})
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .curIndex(curIndex), .ioRdData(ioRdData),
    .shadowFlat(shadowFlat), .commitPulse(commitPulse)
  );

  assign mDivOut   = shadowFlat[0*DATA_W +: DATA_W];
  assign nDivOut   = shadowFlat[1*DATA_W +: DATA_W];
  assign pParamOut = shadowFlat[2*DATA_W +: DATA_W];

endmodule

// File: rtl/pll_param_chk.sv
module pll_param_chk #(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] INDEX_PORT = 16'h03D6,
  parameter logic [ADDR_W-1:0] DATA_PORT  = 16'h03D7,
  parameter logic [DATA_W-1:0] DEF_M      = 8'h1C,
  parameter logic [DATA_W-1:0] DEF_N      = 8'h4A,
  parameter logic [DATA_W-1:0] DEF_P      = 8'h01
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWrEn,
  input logic [DATA_W-1:0] ioRdData,
  input logic [DATA_W-1:0] mDivOut,
  input logic [DATA_W-1:0] nDivOut,
  input logic [DATA_W-1:0] pParamOut,
  input logic              commitPulse
);

  // R4
  reset_defaults_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (mDivOut == DEF_M && nDivOut == DEF_N &&
                     pParamOut == DEF_P && !commitPulse));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitPulse |-> ($stable(mDivOut) && $stable(nDivOut) && $stable(pParamOut)));

  // R8
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  // R8
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(ioWrEn && ioAddr == DATA_PORT));

  // R3
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ioAddr != INDEX_PORT && ioAddr != DATA_PORT) |-> ioRdData == '0);

endmodule

bind pll_param_regs pll_param_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_PORT(INDEX_PORT),
  .DATA_PORT(DATA_PORT), .DEF_M(DEF_M), .DEF_N(DEF_N), .DEF_P(DEF_P)
) u_chk (
  .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
  .ioRdData(ioRdData), .mDivOut(mDivOut), .nDivOut(nDivOut),
  .pParamOut(pParamOut), .commitPulse(commitPulse)
);

// File: tb/sim_pll_param_regs.sv
module sim_pll_param_regs;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [15:0] ioAddr = 16'h0;
  logic       ioWrEn = 1'b0;
  logic [7:0] ioWrData = 8'h0;
  logic [7:0] ioRdData, mDivOut, nDivOut, pParamOut;
  logic       commitPulse;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pll_param_regs u0 (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioWrEn(ioWrEn),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .mDivOut(mDivOut),
    .nDivOut(nDivOut), .pParamOut(pParamOut), .commitPulse(commitPulse)
  );

  // {addr, data, expM, expN, expP, expPulse}
  localparam int NV = 34;
  localparam logic [48:0] VEC [NV] = '{
    {16'h3D6, 8'hCC, 8'h1C, 8'h4A, 8'h01, 1'b0},
    {16'h3D7, 8'h11, 8'h1C, 8'h4A, 8'h01, 1'b0},
    {16'h3D6, 8'hCD, 8'h1C, 8'h4A, 8'h01, 1'b0},
    {16'h3D7, 8'h22, 8'h1C, 8'h4A, 8'h01, 1'b0},
    {16'h3D6, 8'hCE, 8'h1C, 8'h4A, 8'h01, 1'b0},
    {16'h3D7, 8'h33, 8'h11, 8'h22, 8'h33, 1'b1},
    {16'h3D6, 8'hCD, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'h44, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCE, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'h55, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCC, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'h66, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCE, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'h77, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCD, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'h88, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCE, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'h99, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCC, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'hA1, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCD, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'hA2, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'h40, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'hFF, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D6, 8'hCE, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D5, 8'hCC, 8'h11, 8'h22, 8'h33, 1'b0},
    {16'h3D7, 8'hA3, 8'hA1, 8'hA2, 8'hA3, 1'b1},
    {16'h3D6, 8'hCC, 8'hA1, 8'hA2, 8'hA3, 1'b0},
    {16'h3D7, 8'hB1, 8'hA1, 8'hA2, 8'hA3, 1'b0},
    {16'h3D7, 8'hB2, 8'hA1, 8'hA2, 8'hA3, 1'b0},
    {16'h3D6, 8'hCD, 8'hA1, 8'hA2, 8'hA3, 1'b0},
    {16'h3D7, 8'hB3, 8'hA1, 8'hA2, 8'hA3, 1'b0},
    {16'h3D6, 8'hCE, 8'hA1, 8'hA2, 8'hA3, 1'b0},
    {16'h3D7, 8'hB4, 8'hB2, 8'hB3, 8'hB4, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a;
    #1 d = ioRdData;
  endtask

  task automatic checkOuts(input string req, input logic [7:0] m, input logic [7:0] n,
                           input logic [7:0] p, input logic pl);
    check(req, {mDivOut, nDivOut, pParamOut, 7'd0, commitPulse}, {m, n, p, 7'd0, pl});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R4: held in reset
    checkOuts("R4 reset shadows", 8'h1C, 8'h4A, 8'h01, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOuts("R4 after reset", 8'h1C, 8'h4A, 8'h01, 1'b0);
    ioRead(16'h3D6, rd); check("R4 index reset", {24'd0, rd}, 32'h00);
    ioRead(16'h3D7, rd); check("R3 unimplemented index 00", {24'd0, rd}, 32'h00);

    // R5 R6 R7 R8 R9: vector walk
    for (int i = 0; i < NV; i++) begin
      ioWrite(VEC[i][48:33], VEC[i][32:25]);
      checkOuts($sformatf("R5/R6/R7/R8/R9 vec %0d", i),
                VEC[i][24:17], VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
      if (VEC[i][0]) begin
        @(negedge clk);
        check("R8 pulse one cycle", {31'd0, commitPulse}, 32'd0);
      end
    end

    // R1 index readback, R2 staging readback
    ioRead(16'h3D6, rd); check("R1 index readback", {24'd0, rd}, 32'hCE);
    ioRead(16'h3D7, rd); check("R2 staging P", {24'd0, rd}, 32'hB4);
    ioWrite(16'h3D6, 8'hCC);
    ioRead(16'h3D7, rd); check("R2 staging M", {24'd0, rd}, 32'hB2);
    ioWrite(16'h3D6, 8'hCD);
    ioRead(16'h3D7, rd); check("R2 staging N", {24'd0, rd}, 32'hB3);
    // R3: out-of-group index and foreign address
    ioWrite(16'h3D6, 8'h40);
    ioRead(16'h3D7, rd); check("R3 index 40 reads 00", {24'd0, rd}, 32'h00);
    ioWrite(16'h3D6, 8'hCF);
    ioRead(16'h3D7, rd); check("R3 index CF reads 00", {24'd0, rd}, 32'h00);
    ioRead(16'h03D5, rd); check("R3 other address 00", {24'd0, rd}, 32'h00);
    // R7: write to foreign address did not touch index
    ioWrite(16'h3D8, 8'hCC);
    ioRead(16'h3D6, rd); check("R7 foreign write no index", {24'd0, rd}, 32'hCF);

    // R4: reset mid-sequence clears tracker and staging
    ioWrite(16'h3D6, 8'hCC); ioWrite(16'h3D7, 8'hC1);
    ioWrite(16'h3D6, 8'hCD); ioWrite(16'h3D7, 8'hC2);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkOuts("R4 reset mid sequence", 8'h1C, 8'h4A, 8'h01, 1'b0);
    rstN = 1'b1;
    ioWrite(16'h3D6, 8'hCC);
    ioRead(16'h3D7, rd); check("R4 staging default M", {24'd0, rd}, 32'h1C);
    ioWrite(16'h3D6, 8'hCE); ioWrite(16'h3D7, 8'hC3);
    checkOuts("R4 R6 no commit after reset", 8'h1C, 8'h4A, 8'h01, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule